// File: doc/BRIEF.md
# Page Table Walker

This block translates virtual addresses to physical addresses using a single-level page table kept in ordinary memory. A processor presents a virtual address with an access kind (read, write or execute) and, for writes, the data. The walker computes where the matching page table entry lives from a base register, reads that entry over a shared memory port, and inspects its valid and permission flags. A good entry leads to the data access at the physical address. A bad entry leads to a fault that stays visible until the fault handler clears it.

Only one translation is in flight at a time. A write to a page whose entry is not yet marked dirty first writes the entry back with the dirty flag set, then performs the data write. Every request repeats the whole walk. A handler can therefore repair an entry in memory and resend the faulting address, and the resend sees the repaired entry.

Top module: `page_walker`

## Requirements
- R1: Directly after reset the request port is ready, no memory request is active, no fault is flagged and no response is signalled.
- R2: The first memory access of every walk is a read at address base + 4 × VPN, where the VPN is bits VA_W-1..PAGE_BITS of the virtual address and the base is the value last loaded through base_we/base_wdata.
- R3: After issuing a memory request the walker holds mem_req low until mem_rvalid returns, whatever the memory latency, and the number of memory accesses per walk is fixed by the outcome.
- R4: An entry with valid bit 0 (bit 0 of the entry) yields fault_kind 1, with fault_va equal to the request address, and no memory access follows the entry read.
- R5: For a permitted access, the data access goes to the physical page number (entry bits 31..12 by default) concatenated with the unchanged page offset. For reads and executes, rsp_rdata is the data returned for that address.
- R6: The access kind is encoded 0 read, 1 write, 2 execute, 3 reserved. Kinds 0, 1 and 2 need entry bits 1, 2 and 3 respectively, and kind 3 is never permitted. A valid entry without the needed bit yields fault_kind 2 and no data access. An invalid entry reports kind 1 even if permissions are also missing.
- R7: A permitted write to an entry whose dirty bit (bit 4) is 0 writes the entry back to its own address with bit 4 set, before the data write of req_wdata.
- R8: A permitted write to an entry whose dirty bit is already 1 performs no entry write, only the data write.
- R9: fault_valid, fault_kind and fault_va hold until a fault_clr pulse, and fault_clr drops fault_valid.
- R10: req_ready is low from the cycle after acceptance until the response or the fault is delivered, and is high again afterwards.
- R11: A resend of a faulting address after the entry has been changed in memory walks the table again and uses the new entry.
- R12: A base register load changes the entry address used by later walks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| base_we | input | 1 | Load the page table base register |
| base_wdata | input | PA_W | New base address |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle and accepting |
| req_va | input | VA_W | Virtual address |
| req_kind | input | 2 | Access kind: 0 read, 1 write, 2 execute, 3 reserved |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | Data access completed (one cycle) |
| rsp_rdata | output | DATA_W | Read data of the completed access |
| fault_valid | output | 1 | Fault flagged, held until cleared |
| fault_kind | output | 2 | 1 invalid page, 2 access not permitted |
| fault_va | output | VA_W | Virtual address that faulted |
| fault_clr | input | 1 | Clear the fault flag |
| mem_req | output | 1 | Memory request, one cycle per access |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | PA_W | Memory address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_rvalid | input | 1 | Memory completion (read data or write acknowledge) |
| mem_rdata | input | DATA_W | Memory read data |

## Verification
The hardest situation to reach is the ordering of the dirty-flag write-back against the data write. The dirty-flag case also has to be kept apart from a write to a page that is already dirty, since both end in the same response at the ports. The bench's memory model records the sequence number, address and data of every access. It reloads the entry before each walk, so the clean and dirty cases are checked on fresh entries. The whole vector table runs twice, with memory latencies of one and four cycles. A repair-and-resend sequence and a base reload then cover the repeated walk.

// File: rtl/pw_pkg.sv
package pw_pkg;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_EXEC  = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_e;

    typedef enum logic [1:0] {
        FLT_NONE    = 2'd0,
        FLT_INVALID = 2'd1,
        FLT_PERM    = 2'd2
    } flt_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_PTE_REQ,
        S_PTE_WAIT,
        S_CHECK,
        S_DRT_REQ,
        S_DRT_WAIT,
        S_DAT_REQ,
        S_DAT_WAIT
    } st_e;

    localparam int unsigned FLAG_W = 5;
    localparam int unsigned BIT_V  = 0;
    localparam int unsigned BIT_R  = 1;
    localparam int unsigned BIT_W  = 2;
    localparam int unsigned BIT_X  = 3;
    localparam int unsigned BIT_D  = 4;
    localparam int unsigned ENTRY_SHIFT = 2;

    typedef struct packed {
        logic dirty;
        logic exe;
        logic wr;
        logic rd;
        logic valid;
    } flags_t;

    function automatic flags_t unpack_flags(input logic [FLAG_W-1:0] raw);
        flags_t f;
        f.valid = raw[BIT_V];
        f.rd    = raw[BIT_R];
        f.wr    = raw[BIT_W];
        f.exe   = raw[BIT_X];
        f.dirty = raw[BIT_D];
        return f;
    endfunction

    function automatic logic kind_allowed(input acc_e kind, input flags_t f);
        case (kind)
            ACC_READ:  return f.rd;
            ACC_WRITE: return f.wr;
            ACC_EXEC:  return f.exe;
            default:   return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/pw_addr_gen.sv
module pw_addr_gen #(
    parameter int unsigned VA_W      = 32,
    parameter int unsigned PAGE_BITS = 12,
    parameter int unsigned PA_W      = 32,
    parameter int unsigned PPN_W     = 20
) (
    input  logic [PA_W-1:0]  base,
    input  logic [VA_W-1:0]  va,
    input  logic [PPN_W-1:0] ppn,
    output logic [PA_W-1:0]  entry_addr,
    output logic [PA_W-1:0]  phys_addr
);
    import pw_pkg::*;

    localparam int unsigned VPN_W = VA_W - PAGE_BITS;

    logic [VPN_W-1:0]     vpn;
    logic [PAGE_BITS-1:0] offset;

    always_comb begin
        vpn        = va[VA_W-1:PAGE_BITS];
        offset     = va[PAGE_BITS-1:0];
        entry_addr = base + (PA_W'(vpn) << ENTRY_SHIFT);
        phys_addr  = {ppn, offset};
    end

endmodule

// File: rtl/pw_check.sv
module pw_check (
    input  pw_pkg::acc_e              kind,
    input  logic [pw_pkg::FLAG_W-1:0] raw_flags,
    output pw_pkg::flt_e              fault,
    output logic                      mark_dirty
);
    import pw_pkg::*;

    flags_t f;
    logic   ok;

    always_comb begin
        f  = unpack_flags(raw_flags);
        ok = kind_allowed(kind, f);
        if (!f.valid)   fault = FLT_INVALID;
        else if (!ok)   fault = FLT_PERM;
        else            fault = FLT_NONE;
        mark_dirty = f.valid && ok && (kind == ACC_WRITE) && !f.dirty;
    end

endmodule

// File: rtl/pw_ctrl.sv
module pw_ctrl (
    input  logic         clk,
    input  logic         rst,
    input  logic         req_fire,
    input  logic         mem_rvalid,
    input  pw_pkg::flt_e fault,
    input  logic         mark_dirty,
    output pw_pkg::st_e  state
);
    import pw_pkg::*;

    st_e nxt;

    always_comb begin
        nxt = state;
        case (state)
            S_IDLE:     if (req_fire) nxt = S_PTE_REQ;
            S_PTE_REQ:  nxt = S_PTE_WAIT;
            S_PTE_WAIT: if (mem_rvalid) nxt = S_CHECK;
            S_CHECK: begin
                if (fault != FLT_NONE) nxt = S_IDLE;
                else if (mark_dirty)   nxt = S_DRT_REQ;
                else                   nxt = S_DAT_REQ;
            end
            S_DRT_REQ:  nxt = S_DRT_WAIT;
            S_DRT_WAIT: if (mem_rvalid) nxt = S_DAT_REQ;
            S_DAT_REQ:  nxt = S_DAT_WAIT;
            S_DAT_WAIT: if (mem_rvalid) nxt = S_IDLE;
            default:    nxt = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= S_IDLE;
        else     state <= nxt;
    end

endmodule

// File: rtl/page_walker.sv
module page_walker #(
    parameter int unsigned VA_W      = 32,
    parameter int unsigned PAGE_BITS = 12,
    parameter int unsigned PA_W      = 32,
    parameter int unsigned PPN_W     = 20,
    parameter int unsigned DATA_W    = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              base_we,
    input  logic [PA_W-1:0]   base_wdata,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [VA_W-1:0]   req_va,
    input  logic [1:0]        req_kind,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              fault_valid,
    output logic [1:0]        fault_kind,
    output logic [VA_W-1:0]   fault_va,
    input  logic              fault_clr,
    output logic              mem_req,
    output logic              mem_we,
    output logic [PA_W-1:0]   mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_rvalid,
    input  logic [DATA_W-1:0] mem_rdata
);
    import pw_pkg::*;

    localparam int unsigned PPN_LSB = DATA_W - PPN_W;
    localparam logic [DATA_W-1:0] DIRTY_MASK = DATA_W'(1) << BIT_D;

    st_e               state;
    logic [PA_W-1:0]   base_q;
    logic [VA_W-1:0]   va_q;
    acc_e              kind_q;
    logic [DATA_W-1:0] wdata_q;
    logic [PA_W-1:0]   entry_addr_q;
    logic [DATA_W-1:0] entry_q;
    logic [VA_W-1:0]   gen_va;
    logic [PA_W-1:0]   entry_addr;
    logic [PA_W-1:0]   phys_addr;
    flt_e              chk_fault;
    logic              chk_dirty;
    logic              req_fire;

    assign req_ready = (state == S_IDLE);
    assign req_fire  = req_valid && req_ready;
    assign gen_va    = (state == S_IDLE) ? req_va : va_q;

    pw_addr_gen #(
        .VA_W(VA_W), .PAGE_BITS(PAGE_BITS), .PA_W(PA_W), .PPN_W(PPN_W)
    ) u_addr (
        .base       (base_q),
        .va         (gen_va),
        .ppn        (entry_q[DATA_W-1:PPN_LSB]),
        .entry_addr (entry_addr),
        .phys_addr  (phys_addr)
    );

    pw_check u_check (
        .kind       (kind_q),
        .raw_flags  (entry_q[FLAG_W-1:0]),
        .fault      (chk_fault),
        .mark_dirty (chk_dirty)
    );

    pw_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .req_fire   (req_fire),
        .mem_rvalid (mem_rvalid),
        .fault      (chk_fault),
        .mark_dirty (chk_dirty),
        .state      (state)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q       <= '0;
            va_q         <= '0;
            kind_q       <= ACC_READ;
            wdata_q      <= '0;
            entry_addr_q <= '0;
            entry_q      <= '0;
        end else begin
            if (base_we) base_q <= base_wdata;
            if (req_fire) begin
                va_q         <= req_va;
                kind_q       <= acc_e'(req_kind);
                wdata_q      <= req_wdata;
                entry_addr_q <= entry_addr;
            end
            if (state == S_PTE_WAIT && mem_rvalid) entry_q <= mem_rdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fault_valid <= 1'b0;
            fault_kind  <= FLT_NONE;
            fault_va    <= '0;
        end else if (state == S_CHECK && chk_fault != FLT_NONE) begin
            fault_valid <= 1'b1;
            fault_kind  <= chk_fault;
            fault_va    <= va_q;
        end else if (fault_clr) begin
            fault_valid <= 1'b0;
        end
    end

    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = entry_addr_q;
        mem_wdata = '0;
        case (state)
            S_PTE_REQ: mem_req = 1'b1;
            S_DRT_REQ: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_wdata = entry_q | DIRTY_MASK;
            end
            S_DAT_REQ: begin
                mem_req   = 1'b1;
                mem_we    = (kind_q == ACC_WRITE);
                mem_addr  = phys_addr;
                mem_wdata = wdata_q;
            end
            default: ;
        endcase
    end

    assign rsp_valid = (state == S_DAT_WAIT) && mem_rvalid;
    assign rsp_rdata = mem_rdata;

endmodule

// File: rtl/pw_checker.sv
module pw_checker (
    input logic clk,
    input logic rst,
    input logic req_valid,
    input logic req_ready,
    input logic rsp_valid,
    input logic fault_valid,
    input logic fault_clr,
    input logic mem_req
);

    p_reset_idle_r1: assert property (@(posedge clk)
        rst |=> (req_ready && !mem_req && !fault_valid));

    p_one_access_r3: assert property (@(posedge clk) disable iff (rst)
        mem_req |=> !mem_req);

    p_fault_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (fault_valid && !fault_clr) |=> fault_valid);

    p_busy_after_accept_r10: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready);

    p_ready_after_rsp_r10: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> req_ready);

    p_quiet_when_idle_r10: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> !mem_req);

endmodule

bind page_walker pw_checker u_pw_checker (
    .clk         (clk),
    .rst         (rst),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .rsp_valid   (rsp_valid),
    .fault_valid (fault_valid),
    .fault_clr   (fault_clr),
    .mem_req     (mem_req)
);

// File: tb/page_walker_bench.sv
module page_walker_bench;

    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] BASE  = 32'h0008_0000;
    localparam logic [31:0] BASE2 = 32'h0008_0040;
    localparam logic [31:0] SALT  = 32'h5A5A_0000;

    typedef struct packed {
        logic [19:0] vpn;
        logic [11:0] off;
        logic [1:0]  kind;
        logic [31:0] pte;
        logic [1:0]  efault;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VEC [NV] = '{
        '{20'd1, 12'h456, 2'd0, 32'h0012_3003, 2'd0},
        '{20'd2, 12'hABC, 2'd2, 32'h0020_0009, 2'd0},
        '{20'd3, 12'h010, 2'd1, 32'h0030_0007, 2'd0},
        '{20'd4, 12'h7F0, 2'd1, 32'h0040_0015, 2'd0},
        '{20'd5, 12'h001, 2'd0, 32'h0050_0002, 2'd1},
        '{20'd6, 12'h002, 2'd1, 32'h0060_0003, 2'd2},
        '{20'd7, 12'h003, 2'd2, 32'h0070_0007, 2'd2},
        '{20'd8, 12'h004, 2'd3, 32'h0080_001F, 2'd2},
        '{20'd9, 12'h005, 2'd1, 32'h0090_0000, 2'd1}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        base_we = 1'b0;
    logic [31:0] base_wdata = '0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_va = '0;
    logic [1:0]  req_kind = '0;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    logic        fault_valid;
    logic [1:0]  fault_kind;
    logic [31:0] fault_va;
    logic        fault_clr = 1'b0;
    logic        mem_req;
    logic        mem_we;
    logic [31:0] mem_addr;
    logic [31:0] mem_wdata;
    logic        mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;

    int total = 0;
    int fails = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    page_walker u_page_walker (
        .clk(clk), .rst(rst), .base_we(base_we), .base_wdata(base_wdata),
        .req_valid(req_valid), .req_ready(req_ready), .req_va(req_va),
        .req_kind(req_kind), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .fault_valid(fault_valid), .fault_kind(fault_kind), .fault_va(fault_va),
        .fault_clr(fault_clr),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
    );

    // memory model: table region of 32 entries, everything else returns address ^ SALT
    logic [31:0] pt [32];
    int          lat = 1;
    int          pend = 0;
    logic [31:0] pend_data = '0;
    int          mcnt = 0;
    logic [31:0] first_addr = '0;
    logic        first_we = 1'b0;
    int          ptw_seq = -1;
    logic [31:0] ptw_val = '0;
    int          dat_seq = -1;
    logic [31:0] dat_addr = '0;
    logic        dat_we = 1'b0;
    logic [31:0] dat_wdata = '0;

    always @(posedge clk) begin
        mem_rvalid <= 1'b0;
        if (pend > 0) begin
            pend <= pend - 1;
            if (pend == 1) begin
                mem_rvalid <= 1'b1;
                mem_rdata  <= pend_data;
            end
        end
        if (mem_req) begin
            mcnt <= mcnt + 1;
            if (mcnt == 0) begin
                first_addr <= mem_addr;
                first_we   <= mem_we;
            end
            if (mem_addr >= BASE && mem_addr < BASE + 32'd128) begin
                if (mem_we) begin
                    pt[(mem_addr - BASE) >> 2] <= mem_wdata;
                    ptw_seq <= mcnt;
                    ptw_val <= mem_wdata;
                end
                pend_data <= pt[(mem_addr - BASE) >> 2];
            end else begin
                dat_seq   <= mcnt;
                dat_addr  <= mem_addr;
                dat_we    <= mem_we;
                dat_wdata <= mem_wdata;
                pend_data <= mem_addr ^ SALT;
            end
            pend <= lat;
        end
    end

    task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    logic        got_rsp;
    logic        got_flt;
    logic [31:0] got_data;
    logic        busy_ready_seen;

    task automatic clear_fault();
        @(negedge clk);
        fault_clr = 1'b1;
        @(negedge clk);
        fault_clr = 1'b0;
    endtask

    task automatic walk(input logic [31:0] va, input logic [1:0] kind, input logic [31:0] wd);
        @(negedge clk);
        mcnt = 0; ptw_seq = -1; dat_seq = -1;
        req_va = va; req_kind = kind; req_wdata = wd; req_valid = 1'b1;
        got_rsp = 1'b0; got_flt = 1'b0; got_data = '0; busy_ready_seen = 1'b0;
        for (int k = 0; k < 80; k++) begin
            @(negedge clk);
            req_valid = 1'b0;
            if (rsp_valid) begin
                got_rsp = 1'b1;
                got_data = rsp_rdata;
                break;
            end
            if (fault_valid) begin
                got_flt = 1'b1;
                break;
            end
            if (req_ready) busy_ready_seen = 1'b1;
        end
        if (got_rsp) @(negedge clk);
    endtask

    task automatic run_vec(input vec_t v, input int idx);
        logic [31:0] va;
        logic [31:0] pa;
        logic [31:0] wd;
        logic        clean_wr;
        int          ecnt;
        va = {v.vpn, v.off};
        pa = {v.pte[31:12], v.off};
        wd = 32'hC0DE_0000 | idx;
        pt[v.vpn[4:0]] = v.pte;
        clear_fault();
        walk(va, v.kind, wd);
        clean_wr = (v.efault == 2'd0) && (v.kind == 2'd1) && !v.pte[4];
        ecnt = (v.efault != 2'd0) ? 1 : (clean_wr ? 3 : 2);
        check(first_addr == BASE + (32'(v.vpn) << 2) && !first_we, "R2 entry read address",
              first_addr, BASE + (32'(v.vpn) << 2));
        check(mcnt == ecnt, "R3 access count", 32'(mcnt), 32'(ecnt));
        check(!busy_ready_seen, "R10 ready low while busy", 32'(busy_ready_seen), 0);
        check(req_ready, "R10 ready after completion", 32'(req_ready), 1);
        if (v.efault == 2'd1) begin
            check(got_flt && fault_kind == 2'd1, "R4 invalid fault kind", 32'(fault_kind), 1);
            check(fault_va == va, "R4 fault address", fault_va, va);
            check(dat_seq == -1, "R4 no data access", 32'(dat_seq), 32'hFFFF_FFFF);
        end else if (v.efault == 2'd2) begin
            check(got_flt && fault_kind == 2'd2, "R6 permission fault kind", 32'(fault_kind), 2);
            check(dat_seq == -1, "R6 no data access", 32'(dat_seq), 32'hFFFF_FFFF);
        end else begin
            check(got_rsp && !fault_valid, "R6 permitted access completes", 32'(got_rsp), 1);
            check(dat_addr == pa, "R5 physical address", dat_addr, pa);
            if (v.kind == 2'd1) begin
                check(dat_we && dat_wdata == wd, "R7 data write value", dat_wdata, wd);
                if (clean_wr) begin
                    check(ptw_val == (v.pte | 32'h10), "R7 dirty write-back value", ptw_val, v.pte | 32'h10);
                    check(ptw_seq == 1 && dat_seq == 2, "R7 write-back before data", 32'(ptw_seq), 1);
                end else begin
                    check(ptw_seq == -1, "R8 no entry write on dirty page", 32'(ptw_seq), 32'hFFFF_FFFF);
                end
            end else begin
                check(!dat_we && got_data == (pa ^ SALT), "R5 read data", got_data, pa ^ SALT);
            end
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        fails++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        for (int i = 0; i < 32; i++) pt[i] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        check(req_ready, "R1 ready in reset", 32'(req_ready), 1);
        check(!mem_req && !fault_valid && !rsp_valid, "R1 quiet in reset",
              {29'd0, mem_req, fault_valid, rsp_valid}, 0);
        rst = 1'b0;
        @(negedge clk);
        check(req_ready && !mem_req && !fault_valid, "R1 idle after reset",
              {29'd0, req_ready, mem_req, fault_valid}, 32'h4);
        base_we = 1'b1; base_wdata = BASE;
        @(negedge clk);
        base_we = 1'b0;

        // vector table, short then long memory latency (R3)
        for (int pass = 0; pass < 2; pass++) begin
            lat = (pass == 0) ? 1 : 4;
            for (int i = 0; i < NV; i++) run_vec(VEC[i], i);
        end
        lat = 1;

        // R9: fault holds, then clears
        pt[5] = 32'h0050_0002;
        clear_fault();
        walk({20'd5, 12'h0AA}, 2'd0, 32'h0);
        repeat (4) @(negedge clk);
        check(fault_valid && fault_kind == 2'd1, "R9 fault held", {30'd0, fault_kind}, 1);
        check(fault_va == {20'd5, 12'h0AA}, "R9 fault address held", fault_va, {20'd5, 12'h0AA});
        fault_clr = 1'b1;
        @(negedge clk);
        fault_clr = 1'b0;
        @(negedge clk);
        check(!fault_valid, "R9 fault cleared", 32'(fault_valid), 0);

        // R11: repair the entry, resend the same address
        pt[5] = 32'h0055_5003;
        walk({20'd5, 12'h0AA}, 2'd0, 32'h0);
        check(got_rsp && !fault_valid, "R11 resend completes", 32'(got_rsp), 1);
        check(dat_addr == 32'h0055_50AA, "R11 resend uses new entry", dat_addr, 32'h0055_50AA);
        check(mcnt == 2, "R11 resend walks again", 32'(mcnt), 2);

        // R12: new base relocates the table
        base_we = 1'b1; base_wdata = BASE2;
        @(negedge clk);
        base_we = 1'b0;
        pt[17] = 32'h0077_7003;
        walk({20'd1, 12'h321}, 2'd0, 32'h0);
        check(first_addr == BASE2 + 32'd4, "R12 entry address from new base", first_addr, BASE2 + 32'd4);
        check(dat_addr == 32'h0077_7321, "R12 translation from new table", dat_addr, 32'h0077_7321);

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule